// File: doc/BRIEF.md
# Keyed Watchdog Interval Counter

This block is an 8-bit up-counter for watchdog or interval use, driven by one of eight prescaled ticks taken from the system clock. A free-running prescaler supplies the ticks, and a 3-bit select field picks which one advances the counter. When the counter wraps from 0xFF to 0x00, a sticky overflow flag is raised. Software can lower that flag only by writing a zero to it, and only after it has seen the flag read back as one.

All register writes are 16-bit words. The upper byte of the word is a key and the lower byte is the data. A write whose key does not match the target register is dropped. Reads are single bytes, one byte address per register. The block has three registers: a control/status byte, the counter itself and a reset-configuration byte.

Top module: `kwdt_top`

## Requirements
- R1: After reset the control/status byte reads 0x18, the counter reads 0x00 and the reset-configuration byte reads 0x3F.
- R2: A word write to address 0 with key 0xA5 (busWdata[15:8]) updates the control/status byte. A word write to address 0 with key 0x5A updates the counter. A word write with any other key changes neither register.
- R3: The control/status byte has this layout: bit 7 is the overflow flag, bit 6 reads 0, bit 5 is the enable, bits 4:3 read 1 and ignore writes, and bits 2:0 are the clock select.
- R4: While enabled, the counter advances by one on each tick of the selected prescaler. Select values 0 to 7 divide the system clock by 2, 64, 128, 512, 2048, 8192, 32768 and 131072, and the counter holds between ticks.
- R5: A keyed counter write while enabled loads the data byte. If a tick arrives in the same cycle, the write takes priority.
- R6: While disabled, the counter is held at 0x00 and keyed counter writes are ignored. A keyed control write that clears the enable bit returns the counter to 0x00 on the next cycle.
- R7: A tick that wraps the counter from 0xFF to 0x00 sets the overflow flag. The flag is also reported on the ovfFlag output.
- R8: Writing 0 to the flag bit clears it only if a control/status read returned the flag as 1 since the flag was last cleared. An overflow in the same cycle as the clear leaves the flag set.
- R9: Writing 1 to the flag bit never sets the flag.
- R10: A word write to address 2 with key 0xA5 stores data bits 7:6 in the reset-configuration byte. Bits 5:0 of that byte always read 1. Any other key is ignored.
- R11: Byte reads return the control/status byte at address 0, the counter at address 1, the reset-configuration byte at address 2 and 0xFF at address 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address, used for both word writes and byte reads |
| busWe | input | 1 | Word write strobe |
| busWdata | input | 16 | Write word: key in bits 15:8, data in bits 7:0 |
| busRe | input | 1 | Byte read strobe |
| busRdata | output | 8 | Read data, combinational from busAddr |
| ovfFlag | output | 1 | Current value of the overflow flag |

## Verification
The assertions assume the bus drives at most one of busWe and busRe in a cycle. They also assume that busAddr and busWdata are only meaningful while a strobe is high. The stimulus meets these assumptions: every access is a one-cycle strobe, driven shortly after a rising edge and removed before the next access. Because the prescaler phase is not visible at the ports, the bench checks counting rates by the difference between two counter reads taken a fixed number of cycles apart.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_SEL = 8;
  localparam int SEL_W   = $clog2(NUM_SEL);
  localparam logic [7:0] KEY_CTRL = 8'hA5;
  localparam logic [7:0] KEY_CNT  = 8'h5A;

  typedef struct packed {
    logic ctrlWr;
    logic cntWr;
    logic cfgWr;
    logic flagClr;
  } strobe_t;

  // log2 of the division ratio chosen by each select code
  function automatic int divLog(input int idx);
    case (idx)
      0: return 1;
      1: return 6;
      2: return 7;
      3: return 9;
      4: return 11;
      5: return 13;
      6: return 15;
      default: return 17;
    endcase
  endfunction
endpackage

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWe,
  input  logic       busRe,
  input  logic [7:0] keyByte,
  input  logic       flagBit,
  input  logic       flag,
  output strobe_t    strb
);
  logic armed;
  logic atCtrl, atCfg, readHit;

  assign atCtrl  = (busAddr == 2'd0);
  assign atCfg   = (busAddr == 2'd2);
  assign readHit = busRe && atCtrl && flag;

  always_comb begin
    strb.ctrlWr  = busWe && atCtrl && (keyByte == KEY_CTRL);
    strb.cntWr   = busWe && atCtrl && (keyByte == KEY_CNT);
    strb.cfgWr   = busWe && atCfg  && (keyByte == KEY_CTRL);
    strb.flagClr = strb.ctrlWr && !flagBit && armed;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              armed <= 1'b0;
    else if (strb.flagClr)  armed <= 1'b0;
    else if (readHit)       armed <= 1'b1;
  end

  // R8
  arm_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !readHit) |=> !strb.flagClr || !busWe || !armed);
endmodule

// File: rtl/kwdt_dp.sv
module kwdt_dp
  import kwdt_pkg::*;
#(
  parameter int PRE_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              flag
);
  logic [PRE_W-1:0]  preCnt;
  logic [NUM_SEL-1:0] tickVec;
  logic [SEL_W-1:0]  clkSel;
  logic              enable;
  logic [1:0]        cfgHi;
  logic [DATA_W-1:0] cnt;
  logic              tick, wrap, disableWr;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tick
    localparam int L = divLog(g);
    assign tickVec[g] = &preCnt[L-1:0];
  end

  assign tick      = tickVec[clkSel];
  assign disableWr = strb.ctrlWr && !wrData[5];
  assign wrap      = enable && tick && (cnt == '1) && !strb.cntWr && !disableWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0;
      clkSel <= '0;
      cfgHi  <= 2'b00;
      flag   <= 1'b0;
      cnt    <= '0;
    end else begin
      if (strb.ctrlWr) begin
        enable <= wrData[5];
        clkSel <= wrData[SEL_W-1:0];
      end
      if (strb.cfgWr) cfgHi <= wrData[7:6];
      if (wrap)              flag <= 1'b1;
      else if (strb.flagClr) flag <= 1'b0;
      if (!enable || disableWr) cnt <= '0;
      else if (strb.cntWr)      cnt <= wrData;
      else if (tick)            cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (rdAddr)
      2'd0:    rdData = {flag, 1'b0, enable, 2'b11, clkSel};
      2'd1:    rdData = cnt;
      2'd2:    rdData = {cfgHi, 6'h3F};
      default: rdData = 8'hFF;
    endcase
  end

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tick && cnt == 8'hFF && !strb.cntWr && !strb.ctrlWr) |=> flag);
  // R6
  dis_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (cnt == '0));
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tick && !strb.cntWr && !strb.ctrlWr) |=> $stable(cnt));
  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !strb.flagClr) |=> flag);
  // R9
  no_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flag && !(enable && tick && cnt == 8'hFF)) |=> !flag);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int PRE_W = 17
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  busAddr,
  input  logic        busWe,
  input  logic [15:0] busWdata,
  input  logic        busRe,
  output logic [7:0]  busRdata,
  output logic        ovfFlag
);
  strobe_t strb;
  logic    flag;

  kwdt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .keyByte (busWdata[15:8]),
    .flagBit (busWdata[7]),
    .flag    (flag),
    .strb    (strb)
  );

  kwdt_dp #(.PRE_W(PRE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWdata[7:0]),
    .rdAddr (busAddr),
    .rdData (busRdata),
    .flag   (flag)
  );

  assign ovfFlag = flag;
endmodule

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [7:0]  busRdata;
  logic        ovfFlag;

  int testCount = 0;
  int failCount = 0;
  bit peekMode = 1'b0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  kwdt_top u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata), .ovfFlag(ovfFlag)
  );

  task automatic checkVal(input string tag, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each scored read
  always @(negedge clk) begin
    if (busRe && !peekMode && expQ.size() > 0)
      checkVal(tagQ.pop_front(), busRdata, expQ.pop_front());
  end

  task automatic wrWord(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic rdExpect(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    expQ.push_back(e); tagQ.push_back(tag);
    busAddr = a; busRe = 1'b1;
    @(posedge clk); #1;
    busRe = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    peekMode = 1'b1; busAddr = a; busRe = 1'b1;
    @(negedge clk);
    v = busRdata;
    @(posedge clk); #1;
    busRe = 1'b0; peekMode = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testCount + 1, failCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b;
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;

    rdExpect(2'd0, 8'h18, "R1 ctrl reset");
    rdExpect(2'd1, 8'h00, "R1 counter reset");
    rdExpect(2'd2, 8'h3F, "R1 cfg reset");
    rdExpect(2'd3, 8'hFF, "R11 unused address");

    wrWord(2'd0, 16'h3327);
    rdExpect(2'd0, 8'h18, "R2 bad key ctrl unchanged");

    wrWord(2'd0, 16'hA5FF);
    rdExpect(2'd0, 8'h3F, "R3 reserved bits and flag write 1");
    checkVal("R9 ovfFlag after writing 1", ovfFlag, 0);
    wrWord(2'd0, 16'hA527);
    wrWord(2'd0, 16'h5A80);
    rdExpect(2'd1, 8'h80, "R5 keyed counter write");
    wrWord(2'd0, 16'h3344);
    rdExpect(2'd1, 8'h80, "R2 bad key counter unchanged");

    wrWord(2'd0, 16'hA507);
    rdExpect(2'd1, 8'h00, "R6 disable clears counter");
    wrWord(2'd0, 16'h5A44);
    rdExpect(2'd1, 8'h00, "R6 write while disabled ignored");

    wrWord(2'd0, 16'hA520);
    peek(2'd1, a);
    repeat (18) @(posedge clk);
    peek(2'd1, b);
    checkVal("R4 div2 rate", 8'(b - a), 10);

    wrWord(2'd0, 16'hA521);
    peek(2'd1, a);
    repeat (254) @(posedge clk);
    peek(2'd1, b);
    checkVal("R4 div64 rate", 8'(b - a), 4);

    wrWord(2'd0, 16'hA520);
    wrWord(2'd0, 16'h5AFD);
    repeat (10) @(posedge clk);
    checkVal("R7 ovfFlag set on wrap", ovfFlag, 1);
    wrWord(2'd0, 16'hA520);
    rdExpect(2'd0, 8'hB8, "R8 clear before read ignored");
    wrWord(2'd0, 16'hA500);
    rdExpect(2'd0, 8'h18, "R8 clear after read");
    wrWord(2'd0, 16'hA580);
    rdExpect(2'd0, 8'h18, "R9 writing 1 leaves flag clear");

    wrWord(2'd2, 16'h33C0);
    rdExpect(2'd2, 8'h3F, "R10 bad key cfg ignored");
    wrWord(2'd2, 16'hA5C0);
    rdExpect(2'd2, 8'hFF, "R10 keyed cfg write");

    repeat (3) @(posedge clk);
    checkVal("scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule